// File: doc/BRIEF.md
# Flow-Through Synchronous Static RAM Model

This block is a synthesizable, cycle-accurate model of a single-ported synchronous static RAM with flow-through output. It is meant to sit on the memory side of a testbench when a memory controller is being verified. Address and control are registered on a rising clock edge. The read word comes combinationally from that registered address, so it is valid well before the next edge. Reads and writes may follow one another on back-to-back edges with no idle cycle between them.

A command starts when chip select is low and either of the two address strobes is low. An internal 2-bit burst counter can then step the low address bits on later edges, in linear or interleaved order, to give one word per clock. Writes take their data and per-byte enables on the same edge that registers the address. The bidirectional data bus is split into an input word, an output word and a drive flag. The drive flag also serves as the data-valid flag. The storage depth is a parameter. Address bits above the stored width alias onto the stored words.

The pins are plain control pins with no valid/ready stream. The block never applies back-pressure and accepts a new command on every edge. A controller that does not want a word simply leaves the strobes and the advance input high.

Top module: `ssram_ft_model`

## Requirements
- R1: After reset, `q_drive` is low and `dout` is zero, and an advance request before the first load produces no drive.
- R2: On an edge with `cs_n` low and `strobe_ctl_n` or `strobe_host_n` low, `addr` is captured and the burst counter is cleared. The command is a write if `wr_n` is low and a read otherwise. An address strobe takes precedence over `burst_adv_n` on the same edge.
- R3: After a read is registered on an edge, the addressed word appears on `dout` with `q_drive` high during the cycle that follows that edge, provided `out_en_n` is low.
- R4: `q_drive` is low and `dout` is zero whenever `out_en_n` is high or the current command is a write.
- R5: In a write, byte lane i (bits 8i+7 down to 8i of `din`) is stored only when `byte_wr_n[i]` is 0. Lanes whose enable is 1 keep their old contents.
- R6: A read registered on the edge right after a write to the same address returns the newly written word. Reads and writes may alternate on consecutive edges.
- R7: While a command is active, an edge with both strobes high and `burst_adv_n` low increments the 2-bit burst count, and each step is a read or a write according to `wr_n`. With `burst_order` = 0 the low two address bits are (base + count) mod 4. With `burst_order` = 1 they are base XOR count. The upper address bits do not change.
- R8: While a command is active, an edge with both strobes and `burst_adv_n` high keeps the address. That edge repeats the access as a read or a write according to `wr_n`.
- R9: An edge with a strobe low while `cs_n` is high deselects the device: no word is written, `q_drive` stays low, and later advance requests are ignored until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| cs_n | input | 1 | Active-low chip select, sampled with the strobes |
| strobe_ctl_n | input | 1 | Active-low address strobe, controller side |
| strobe_host_n | input | 1 | Active-low address strobe, second source |
| burst_adv_n | input | 1 | Active-low burst advance |
| wr_n | input | 1 | Active-low global write strobe |
| byte_wr_n | input | 4 | Active-low per-byte write enables |
| burst_order | input | 1 | Burst ordering: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Active-low output enable |
| addr | input | 18 | Word address |
| din | input | 32 | Write data (input half of the data bus) |
| dout | output | 32 | Read data (output half of the data bus), zero when not driven |
| q_drive | output | 1 | High when the model drives the bus with a valid read word |

## Verification
Two functions can land on the same edge. The first pair is a burst advance and a fresh address strobe: the bench runs a burst and then asserts a strobe together with `burst_adv_n`. It judges the case by the word that follows, which must come from the newly strobed address and not from the next burst slot. The second pair is a write and a following read of the same location on adjacent edges. The bench checks that the read word holds the data just written, merged by byte, with no stale value and no idle cycle.

// File: rtl/ssram_pkg.sv
package ssram_pkg;

  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  function automatic logic [BURST_W-1:0] burst_offset(
    input logic [BURST_W-1:0] base,
    input logic [BURST_W-1:0] cnt,
    input order_e             ord
  );
    if (ord == ORD_LINEAR) return base + cnt;
    return base ^ cnt;
  endfunction

endpackage

// File: rtl/ssram_addr_ctrl.sv
module ssram_addr_ctrl
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              strobe_hit,
  input  logic              adv_n,
  input  logic              wr_n,
  input  order_e            order,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] next_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output op_e               next_op,
  output op_e               cur_op
);

  logic [ADDR_W-1:0]  base_q, base_d;
  logic [BURST_W-1:0] cnt_q, cnt_d;
  op_e                op_q, op_d;
  logic               load, desel, running;

  assign load    = !cs_n && strobe_hit;
  assign desel   = cs_n && strobe_hit;
  assign running = (op_q != OP_IDLE);

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    op_d   = OP_IDLE;
    if (load) begin
      base_d = addr_in;
      cnt_d  = '0;
      op_d   = wr_n ? OP_READ : OP_WRITE;
    end else if (desel) begin
      op_d = OP_IDLE;
    end else if (running) begin
      if (!adv_n) cnt_d = cnt_q + BURST_W'(1);
      op_d = wr_n ? OP_READ : OP_WRITE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      op_q   <= OP_IDLE;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      op_q   <= op_d;
    end
  end

  assign next_addr = {base_d[ADDR_W-1:BURST_W], burst_offset(base_d[BURST_W-1:0], cnt_d, order)};
  assign cur_addr  = {base_q[ADDR_W-1:BURST_W], burst_offset(base_q[BURST_W-1:0], cnt_q, order)};
  assign next_op   = op_d;
  assign cur_op    = op_q;

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && strobe_hit) |=> (cur_addr == $past(addr_in)));

  // R2
  load_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && strobe_hit && !wr_n) |=> (cur_op == OP_WRITE));

  // R7
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_hit && !adv_n && cur_op != OP_IDLE && order == ORD_LINEAR)
    |=> (!$stable(order) ||
         cur_addr[BURST_W-1:0] == $past(cur_addr[BURST_W-1:0]) + BURST_W'(1)));

  // R7
  burst_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_hit && cur_op != OP_IDLE)
    |=> (cur_addr[ADDR_W-1:BURST_W] == $past(cur_addr[ADDR_W-1:BURST_W])));

  // R8
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_hit && adv_n && cur_op != OP_IDLE)
    |=> ($stable(cur_addr) || !$stable(order)));

  // R9
  deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && strobe_hit) |=> (cur_op == OP_IDLE));

  // R9
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_op == OP_IDLE && !strobe_hit) |=> (cur_op == OP_IDLE));

endmodule

// File: rtl/ssram_wr_decode.sv
module ssram_wr_decode
  import ssram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  op_e              next_op,
  input  logic [LANES-1:0] byte_wr_n,
  output logic [LANES-1:0] lane_we
);

  logic wr_cycle;
  assign wr_cycle = (next_op == OP_WRITE);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we[g] = wr_cycle && !byte_wr_n[g];
  end

endmodule

// File: rtl/ssram_array.sv
module ssram_array #(
  parameter int STORE_W = 8,
  parameter int LANES   = 4,
  parameter int LANE_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES-1:0]          lane_we,
  input  logic [STORE_W-1:0]        waddr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic [STORE_W-1:0]        raddr,
  output logic [LANES*LANE_W-1:0]   rdata
);

  localparam int DEPTH = 1 << STORE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[g]) lane_mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = lane_mem[raddr];

    // R5
    lane_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane_we[g] |=> ((raddr != $past(waddr)) ||
                      (rdata[g*LANE_W +: LANE_W] == $past(wdata[g*LANE_W +: LANE_W]))));

    // R5
    lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!lane_we[g] && raddr == waddr) |=> ((raddr != $past(raddr)) || $stable(rdata[g*LANE_W +: LANE_W])));
  end

endmodule

// File: rtl/ssram_out_stage.sv
module ssram_out_stage
  import ssram_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_e               cur_op,
  input  logic              out_en_n,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] dout,
  output logic              q_drive
);

  assign q_drive = (cur_op == OP_READ) && !out_en_n;
  assign dout    = q_drive ? rdata : '0;

endmodule

// File: rtl/ssram_ft_model.sv
module ssram_ft_model
  import ssram_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 32,
  parameter int LANE_W  = 8,
  parameter int STORE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       strobe_ctl_n,
  input  logic                       strobe_host_n,
  input  logic                       burst_adv_n,
  input  logic                       wr_n,
  input  logic [DATA_W/LANE_W-1:0]   byte_wr_n,
  input  logic                       burst_order,
  input  logic                       out_en_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          din,
  output logic [DATA_W-1:0]          dout,
  output logic                       q_drive
);

  localparam int LANES = DATA_W / LANE_W;

  logic              strobe_hit;
  logic [ADDR_W-1:0] next_addr, cur_addr;
  op_e               next_op, cur_op;
  order_e            order;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] rdata;

  assign strobe_hit = !strobe_ctl_n || !strobe_host_n;
  assign order      = order_e'(burst_order);

  ssram_addr_ctrl #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .strobe_hit(strobe_hit),
    .adv_n     (burst_adv_n),
    .wr_n      (wr_n),
    .order     (order),
    .addr_in   (addr),
    .next_addr (next_addr),
    .cur_addr  (cur_addr),
    .next_op   (next_op),
    .cur_op    (cur_op)
  );

  ssram_wr_decode #(.LANES(LANES)) u_wdec (
    .next_op  (next_op),
    .byte_wr_n(byte_wr_n),
    .lane_we  (lane_we)
  );

  ssram_array #(.STORE_W(STORE_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk    (clk),
    .rst_n  (rst_n),
    .lane_we(lane_we),
    .waddr  (next_addr[STORE_W-1:0]),
    .wdata  (din),
    .raddr  (cur_addr[STORE_W-1:0]),
    .rdata  (rdata)
  );

  ssram_out_stage #(.DATA_W(DATA_W)) u_out (
    .cur_op  (cur_op),
    .out_en_n(out_en_n),
    .rdata   (rdata),
    .dout    (dout),
    .q_drive (q_drive)
  );

  if (STORE_W < ADDR_W) begin : g_alias
    logic unused_addr_hi;
    assign unused_addr_hi = ^{cur_addr[ADDR_W-1:STORE_W], next_addr[ADDR_W-1:STORE_W]};
  end

  // R4
  wr_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && strobe_hit && !wr_n) |=> !q_drive);

  // R3
  rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && strobe_hit && wr_n) |=> (out_en_n || q_drive));

  // R4
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> (!q_drive && dout == '0));

  // R6
  raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && strobe_hit && !wr_n && byte_wr_n == '0) ##1
    (!cs_n && strobe_hit && wr_n && addr == $past(addr))
    |=> (out_en_n || dout == $past(din, 2)));

endmodule

// File: tb/tb_ssram_ft_model.sv
module tb_ssram_ft_model;

  typedef struct {
    bit          chk;
    bit          drv;
    logic [31:0] data;
    string       tag;
  } item_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cs_n = 1, sa_n = 1, sb_n = 1, adv_n = 1, wr_n = 1, oe_n = 1, ord = 0;
  logic [3:0]  be_n = 4'hF;
  logic [17:0] addr = '0;
  logic [31:0] din = '0;
  logic [31:0] dout;
  logic        q_drive;

  int total = 0;
  int bad = 0;
  bit done = 0;
  item_t sb[$];
  logic [31:0] shadow [int];

  always #2 clk = ~clk;

  ssram_ft_model dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .strobe_ctl_n(sa_n), .strobe_host_n(sb_n),
    .burst_adv_n(adv_n), .wr_n(wr_n), .byte_wr_n(be_n), .burst_order(ord),
    .out_en_n(oe_n), .addr(addr), .din(din), .dout(dout), .q_drive(q_drive)
  );

  // monitor: samples 1 ns after each rising edge, before the driver moves inputs
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        if (it.chk) begin
          logic [31:0] ed;
          ed = it.drv ? it.data : 32'h0;
          total++;
          if (q_drive !== it.drv || dout !== ed) begin
            bad++;
            $display("FAIL %s: drive=%0b dout=%h expected drive=%0b dout=%h",
                     it.tag, q_drive, dout, it.drv, ed);
          end
        end
      end
    end
  end

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] be);
    logic [31:0] r;
    r = old;
    for (int i = 0; i < 4; i++) if (!be[i]) r[i*8 +: 8] = d[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] look(input int a);
    return shadow.exists(a) ? shadow[a] : 32'h0;
  endfunction

  task automatic cyc(input bit c, s_a, s_b, a_v, w, input logic [3:0] be, input bit oe,
                     input logic [17:0] a, input logic [31:0] d,
                     input bit chk, drv, input logic [31:0] ed, input string tag);
    item_t it;
    cs_n = c; sa_n = s_a; sb_n = s_b; adv_n = a_v; wr_n = w; be_n = be; oe_n = oe;
    addr = a; din = d;
    it.chk = chk; it.drv = drv; it.data = ed; it.tag = tag;
    sb.push_back(it);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be, input string tag);
    shadow[a] = merge(look(a), d, be);
    cyc(0, 0, 1, 1, 0, be, 0, 18'(a), d, 1, 0, 32'h0, tag);
  endtask

  task automatic rd(input int a, input bit oe, input string tag);
    cyc(0, 0, 1, 1, 1, 4'hF, oe, 18'(a), 32'h0, 1, !oe, look(a), tag);
  endtask

  // advance step: a is the address the burst should reach
  task automatic step(input int a, input bit w, input logic [31:0] d, input string tag);
    if (!w) begin
      shadow[a] = d;
      cyc(0, 1, 1, 0, 0, 4'h0, 0, 18'h0, d, 1, 0, 32'h0, tag);
    end else begin
      cyc(0, 1, 1, 0, 1, 4'hF, 0, 18'h0, 32'h0, 1, 1, look(a), tag);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R1: watchdog expired, actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    total++;
    if (q_drive !== 1'b0 || dout !== 32'h0) begin
      bad++;
      $display("FAIL R1: drive=%0b dout=%h expected drive=0 dout=0", q_drive, dout);
    end
    // R1: advance before any load gives nothing
    cyc(0, 1, 1, 0, 1, 4'hF, 0, 18'h0, 32'h0, 1, 0, 32'h0, "R1 advance before load");

    // R3: random reads after full writes
    wr(16, 32'hA1B2C3D4, 4'h0, "R4 write no drive");
    wr(17, 32'h0BADF00D, 4'h0, "R4 write no drive");
    wr(32, 32'hCAFE1234, 4'h0, "R4 write no drive");
    rd(32, 0, "R3 read 32");
    rd(16, 0, "R3 read 16");
    rd(17, 0, "R3 read 17");

    // R5: byte lanes 0 and 2 written
    wr(16, 32'h11223344, 4'b1010, "R5 byte write");
    rd(16, 0, "R5 byte merge");
    wr(17, 32'hFFEEDDCC, 4'b0111, "R5 byte write lane3");
    rd(17, 0, "R5 lane3 only");
    wr(17, 32'h99999999, 4'hF, "R5 no lanes");
    rd(17, 0, "R5 all lanes kept");

    // R6: alternating write/read same address, no idle
    wr(48, 32'h5A5A0001, 4'h0, "R6 write");
    rd(48, 0, "R6 read after write");
    wr(48, 32'h0000BEEF, 4'b1100, "R6 write lanes");
    rd(48, 0, "R6 read after byte write");
    rd(16, 0, "R6 read other");

    // R4: output enable high
    rd(32, 1, "R4 oe high");

    // R7: linear burst from base 2 (2,3,0,1) using second strobe
    for (int i = 0; i < 4; i++) wr(64 + i, 32'h40400000 + i, 4'h0, "R4 write no drive");
    ord = 0;
    cyc(0, 1, 0, 1, 1, 4'hF, 0, 18'd66, 32'h0, 1, 1, look(66), "R2 second strobe load");
    step(67, 1, 0, "R7 linear 3");
    step(64, 1, 0, "R7 linear wrap 0");
    step(65, 1, 0, "R7 linear 1");

    // R7: interleaved burst from base 1 (1,0,3,2)
    ord = 1;
    rd(65, 0, "R7 interleave load");
    step(64, 1, 0, "R7 interleave 0");
    step(67, 1, 0, "R7 interleave 3");
    step(66, 1, 0, "R7 interleave 2");
    ord = 0;

    // R7: burst write
    wr(80, 32'h80808080, 4'h0, "R4 write no drive");
    step(81, 0, 32'h81818181, "R7 burst write");
    rd(81, 0, "R7 burst write readback");
    rd(80, 0, "R7 burst write base");

    // R8: hold repeats the access
    rd(32, 0, "R8 load");
    cyc(0, 1, 1, 1, 1, 4'hF, 0, 18'd16, 32'h0, 1, 1, look(32), "R8 hold");

    // R2: strobe wins over advance
    rd(64, 0, "R2 burst start");
    cyc(0, 0, 1, 0, 1, 4'hF, 0, 18'd17, 32'h0, 1, 1, look(17), "R2 strobe over advance");

    // R9: deselect, no write, advance ignored
    cyc(1, 0, 1, 1, 0, 4'h0, 0, 18'd48, 32'hDEADDEAD, 1, 0, 32'h0, "R9 deselect write");
    cyc(0, 1, 1, 0, 1, 4'hF, 0, 18'h0, 32'h0, 1, 0, 32'h0, "R9 advance ignored");
    rd(48, 0, "R9 deselected write not stored");

    cyc(1, 1, 1, 1, 1, 4'hF, 1, 18'h0, 32'h0, 0, 0, 32'h0, "idle");
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule